// File: doc/BRIEF.md
# Dual-Rate Queue Scheduler with Band Marking

This block is the egress scheduler for one port. It sits in front of a set of packet queues, each with its own committed-rate and excess-rate token bucket. Whenever the link can accept a packet, the block picks the queue to send from and emits the queue index. It also emits a band code that tells which scheduling band produced the grant, and a per-queue mark value for that band. The mark is a code point that downstream logic writes into the packet header.

The selection runs in a fixed order. Strict-priority queues go first. Next, non-strict queues are served from their committed buckets, then from their excess buckets. Last comes a best-effort round, open only to queues that opt in. Each of the three rate passes has its own rotating pointer. The block also checks every arriving packet against its queue's packet limit and reports a tail drop. Packet storage and the occupancy counters live outside. The block sees only each queue's head length and occupancy.

Top module: `qs_sched`

## Requirements
- R1: After reset, gnt_vld_o and drop_o are 0 and every token bucket is empty, so no committed or excess grant is made before a refill.
- R2: Each bucket is a byte count. On tick_i it gains its increment, capped at its burst size. A grant in its band removes the head length, floored at 0. Both happen in the same cycle when they coincide.
- R3: A non-strict queue with occupancy above 0 is eligible in the committed or excess band only when that band is enabled for it and the bucket holds at least the head length.
- R4: The pass order is strict, then committed, then excess, then best-effort. An excess grant happens only when no queue is strict-ready or committed-eligible.
- R5: A best-effort grant goes only to a non-strict queue with occupancy above 0 whose opt-in flag is set. Such a grant changes no bucket.
- R6: A strict queue with occupancy above 0 wins before any rate pass, and the lowest index wins among strict queues. Its grant carries band code 0 and the queue's committed mark, and changes no bucket.
- R7: Each rate pass searches from its own pointer upward with wraparound. After a grant in that pass, the pointer moves to one past the granted queue. Pointers of other passes do not move.
- R8: Band codes are 0 for strict, 1 for committed, 2 for excess and 3 for best-effort. gnt_mark_o is the granted queue's committed mark for codes 0 and 1, its excess mark for code 2, and its best-effort mark for code 3.
- R9: A decision is taken in a cycle with link_rdy_i high and shows on the outputs one cycle later. With link_rdy_i low, gnt_vld_o is 0 in the next cycle and no bucket loses tokens.
- R10: An arrival (arr_vld_i) for a queue whose occupancy is at or above its packet limit sets drop_o with drop_q_o equal to that queue one cycle later. Otherwise drop_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Bucket refill pulse |
| link_rdy_i | input | 1 | Link can take a packet; take a decision |
| head_len_i | input | NQ*TW | Head packet length in bytes, per queue |
| occ_i | input | NQ*CW | Queue occupancy in packets, per queue |
| strict_i | input | NQ | Strict-priority flag per queue |
| cir_en_i | input | NQ | Committed band enable per queue |
| eir_en_i | input | NQ | Excess band enable per queue |
| be_en_i | input | NQ | Best-effort opt-in per queue |
| cir_inc_i | input | NQ*TW | Committed refill per tick |
| cir_burst_i | input | NQ*TW | Committed bucket cap |
| eir_inc_i | input | NQ*TW | Excess refill per tick |
| eir_burst_i | input | NQ*TW | Excess bucket cap |
| mark_cir_i | input | NQ*MW | Mark for committed and strict grants |
| mark_eir_i | input | NQ*MW | Mark for excess grants |
| mark_be_i | input | NQ*MW | Mark for best-effort grants |
| qlim_i | input | NQ*CW | Packet limit per queue |
| arr_vld_i | input | 1 | Packet arrival strobe |
| arr_q_i | input | QW | Arrival queue index |
| gnt_vld_o | output | 1 | Grant valid |
| gnt_q_o | output | QW | Granted queue |
| gnt_band_o | output | 2 | Band code of the grant |
| gnt_mark_o | output | MW | Mark for the grant |
| drop_o | output | 1 | Tail drop indication |
| drop_q_o | output | QW | Queue of the dropped arrival |

## Verification
The case hardest to reach from the ports is an excess or best-effort grant that follows the rules. It needs some queues to hold committed demand while their committed buckets are too low for their head lengths. In the same cycles, other queues must hold enough excess tokens, and the pointers of the three passes must sit at different places. The stimulus gets there with phases of random configurations whose refill increments are small next to the head lengths. Strict flags appear rarely, ticks are sparse and bursts are lowered between phases, so buckets keep falling through the eligibility threshold. An arithmetic model of the buckets and pointers in the bench predicts every grant. Directed runs pin down the burst cap, the strict precedence and an exhaustive occupancy-versus-limit sweep for tail drop.

// File: rtl/qs_pkg.sv
package qs_pkg;
  typedef enum logic [1:0] {
    BAND_SP  = 2'd0,
    BAND_CIR = 2'd1,
    BAND_EIR = 2'd2,
    BAND_BE  = 2'd3
  } band_e;
endpackage

// File: rtl/qs_bucket.sv
module qs_bucket #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          take_i,
  input  logic [TW-1:0] inc_i,
  input  logic [TW-1:0] burst_i,
  input  logic [TW-1:0] len_i,
  output logic [TW-1:0] tok_o
);
  logic [TW:0]   sum;
  logic [TW-1:0] fill, nxt;

  always_comb begin
    sum  = {1'b0, tok_o} + {1'b0, inc_i};
    fill = tok_o;
    if (tick_i) fill = (sum > {1'b0, burst_i}) ? burst_i : sum[TW-1:0];
    nxt = fill;
    if (take_i) nxt = (fill >= len_i) ? fill - len_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               tok_o <= '0;
    else if (tick_i || take_i) tok_o <= nxt;
  end
endmodule

// File: rtl/qs_rr_pick.sv
module qs_rr_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          take_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] ptr_q;

  // descending scan so the nearest request after ptr_q is written last
  always_comb begin
    vld_o = 1'b0;
    idx_o = ptr_q;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[(int'(ptr_q) + k) % N]) begin
        vld_o = 1'b1;
        idx_o = IW'((int'(ptr_q) + k) % N);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ptr_q <= '0;
    else if (take_i && vld_o) ptr_q <= IW'((int'(idx_o) + 1) % N);
  end
endmodule

// File: rtl/qs_sched.sv
module qs_sched
  import qs_pkg::*;
#(
  parameter int NQ = 8,
  parameter int TW = 16,
  parameter int MW = 6,
  parameter int CW = 6,
  localparam int QW = $clog2(NQ),
  localparam int NP = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             link_rdy_i,
  input  logic [NQ*TW-1:0] head_len_i,
  input  logic [NQ*CW-1:0] occ_i,
  input  logic [NQ-1:0]    strict_i,
  input  logic [NQ-1:0]    cir_en_i,
  input  logic [NQ-1:0]    eir_en_i,
  input  logic [NQ-1:0]    be_en_i,
  input  logic [NQ*TW-1:0] cir_inc_i,
  input  logic [NQ*TW-1:0] cir_burst_i,
  input  logic [NQ*TW-1:0] eir_inc_i,
  input  logic [NQ*TW-1:0] eir_burst_i,
  input  logic [NQ*MW-1:0] mark_cir_i,
  input  logic [NQ*MW-1:0] mark_eir_i,
  input  logic [NQ*MW-1:0] mark_be_i,
  input  logic [NQ*CW-1:0] qlim_i,
  input  logic             arr_vld_i,
  input  logic [QW-1:0]    arr_q_i,
  output logic             gnt_vld_o,
  output logic [QW-1:0]    gnt_q_o,
  output logic [1:0]       gnt_band_o,
  output logic [MW-1:0]    gnt_mark_o,
  output logic             drop_o,
  output logic [QW-1:0]    drop_q_o
);
  logic [TW-1:0] len_a   [NQ];
  logic [TW-1:0] cir_tok [NQ];
  logic [TW-1:0] eir_tok [NQ];
  logic [NQ-1:0] has_pkt, sp_req, cir_ok, eir_ok, be_ok;
  logic [NQ-1:0] rr_req [NP];
  logic          rr_vld [NP];
  logic [QW-1:0] rr_idx [NP];

  logic          sel_vld;
  band_e         sel_band;
  logic [QW-1:0] sel_q, sp_idx;
  logic [MW-1:0] sel_mark;
  logic          fire;

  assign fire = link_rdy_i & sel_vld;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign len_a[q]   = head_len_i[q*TW +: TW];
    assign has_pkt[q] = occ_i[q*CW +: CW] != '0;
    assign sp_req[q]  = has_pkt[q] & strict_i[q];
    assign cir_ok[q]  = has_pkt[q] & ~strict_i[q] & cir_en_i[q] & (cir_tok[q] >= len_a[q]);
    assign eir_ok[q]  = has_pkt[q] & ~strict_i[q] & eir_en_i[q] & (eir_tok[q] >= len_a[q]);
    assign be_ok[q]   = has_pkt[q] & ~strict_i[q] & be_en_i[q];

    qs_bucket #(.TW(TW)) u_cir (
      .clk_i, .rst_ni, .tick_i,
      .take_i (fire && sel_band == BAND_CIR && sel_q == QW'(q)),
      .inc_i  (cir_inc_i[q*TW +: TW]),
      .burst_i(cir_burst_i[q*TW +: TW]),
      .len_i  (len_a[q]),
      .tok_o  (cir_tok[q])
    );
    qs_bucket #(.TW(TW)) u_eir (
      .clk_i, .rst_ni, .tick_i,
      .take_i (fire && sel_band == BAND_EIR && sel_q == QW'(q)),
      .inc_i  (eir_inc_i[q*TW +: TW]),
      .burst_i(eir_burst_i[q*TW +: TW]),
      .len_i  (len_a[q]),
      .tok_o  (eir_tok[q])
    );
  end

  assign rr_req[0] = cir_ok;
  assign rr_req[1] = eir_ok;
  assign rr_req[2] = be_ok;

  // pass p serves band code p+1
  for (genvar p = 0; p < NP; p++) begin : g_pass
    qs_rr_pick #(.N(NQ)) u_rr (
      .clk_i, .rst_ni,
      .req_i (rr_req[p]),
      .take_i(fire && sel_band == band_e'(p + 1)),
      .vld_o (rr_vld[p]),
      .idx_o (rr_idx[p])
    );
  end

  always_comb begin
    sp_idx = '0;
    for (int q = NQ - 1; q >= 0; q--) if (sp_req[q]) sp_idx = QW'(q);
  end

  always_comb begin
    sel_vld  = 1'b1;
    sel_band = BAND_SP;
    sel_q    = sp_idx;
    if (sp_req == '0) begin
      if (rr_vld[0])      begin sel_band = BAND_CIR; sel_q = rr_idx[0]; end
      else if (rr_vld[1]) begin sel_band = BAND_EIR; sel_q = rr_idx[1]; end
      else if (rr_vld[2]) begin sel_band = BAND_BE;  sel_q = rr_idx[2]; end
      else                  sel_vld  = 1'b0;
    end
    unique case (sel_band)
      BAND_EIR: sel_mark = mark_eir_i[sel_q*MW +: MW];
      BAND_BE:  sel_mark = mark_be_i[sel_q*MW +: MW];
      default:  sel_mark = mark_cir_i[sel_q*MW +: MW];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_vld_o  <= 1'b0;
      gnt_q_o    <= '0;
      gnt_band_o <= '0;
      gnt_mark_o <= '0;
      drop_o     <= 1'b0;
      drop_q_o   <= '0;
    end else begin
      gnt_vld_o <= fire;
      if (fire) begin
        gnt_q_o    <= sel_q;
        gnt_band_o <= sel_band;
        gnt_mark_o <= sel_mark;
      end
      drop_o   <= arr_vld_i && (occ_i[arr_q_i*CW +: CW] >= qlim_i[arr_q_i*CW +: CW]);
      drop_q_o <= arr_q_i;
    end
  end
endmodule

// File: rtl/qs_sched_chk.sv
module qs_sched_chk
  import qs_pkg::*;
#(
  parameter int NQ = 8,
  parameter int TW = 16,
  localparam int QW = $clog2(NQ)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             link_rdy_i,
  input logic             arr_vld_i,
  input logic [NQ-1:0]    strict_i,
  input logic [NQ-1:0]    cir_en_i,
  input logic [NQ*TW-1:0] cir_burst_i,
  input logic [NQ-1:0]    sp_req,
  input logic [NQ-1:0]    cir_ok,
  input logic [TW-1:0]    cir_tok [NQ],
  input logic             gnt_vld_o,
  input logic [QW-1:0]    gnt_q_o,
  input logic [1:0]       gnt_band_o,
  input logic             drop_o
);
  a_r9_grant_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_vld_o |-> $past(link_rdy_i));

  a_r10_drop_needs_arrival: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> $past(arr_vld_i));

  a_r6_strict_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_vld_o && gnt_band_o != BAND_SP) |-> $past(sp_req) == '0);

  a_r4_excess_after_committed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_vld_o && gnt_band_o == BAND_EIR) |-> $past(cir_ok) == '0);

  a_r3_committed_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_vld_o && gnt_band_o == BAND_CIR) |-> ($past(cir_en_i) & ~$past(strict_i)) >> gnt_q_o != '0);

  for (genvar q = 0; q < NQ; q++) begin : g_cap
    a_r2_cap_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(tick_i) |-> cir_tok[q] <= $past(cir_burst_i[q*TW +: TW]));
  end
endmodule

bind qs_sched qs_sched_chk #(.NQ(NQ), .TW(TW)) u_qs_sched_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .link_rdy_i (link_rdy_i),
  .arr_vld_i  (arr_vld_i),
  .strict_i   (strict_i),
  .cir_en_i   (cir_en_i),
  .cir_burst_i(cir_burst_i),
  .sp_req     (sp_req),
  .cir_ok     (cir_ok),
  .cir_tok    (cir_tok),
  .gnt_vld_o  (gnt_vld_o),
  .gnt_q_o    (gnt_q_o),
  .gnt_band_o (gnt_band_o),
  .drop_o     (drop_o)
);

// File: tb/qs_sched_bench.sv
module qs_sched_bench;
  localparam int NQ = 8, TW = 16, MW = 6, CW = 6, QW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic tick, link, arr_vld;
  logic [QW-1:0] arr_q;
  logic [NQ*TW-1:0] head_len, cinc_v, cbur_v, einc_v, ebur_v;
  logic [NQ*CW-1:0] occ_v, lim_v;
  logic [NQ-1:0] sp_v, ce_v, ee_v, be_v;
  logic [NQ*MW-1:0] mc_v, me_v, mb_v;
  logic gnt_vld, drop;
  logic [QW-1:0] gnt_q, drop_q;
  logic [1:0] gnt_band;
  logic [MW-1:0] gnt_mark;

  int len[NQ], occ[NQ], lim[NQ], cinc[NQ], cbur[NQ], einc[NQ], ebur[NQ];
  bit sp[NQ], ce[NQ], ee[NQ], be[NQ];
  int ctok[NQ], etok[NQ], ptr[3];
  int n_chk = 0, n_bad = 0;

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      head_len[q*TW +: TW] = TW'(len[q]);
      cinc_v[q*TW +: TW]   = TW'(cinc[q]);
      cbur_v[q*TW +: TW]   = TW'(cbur[q]);
      einc_v[q*TW +: TW]   = TW'(einc[q]);
      ebur_v[q*TW +: TW]   = TW'(ebur[q]);
      occ_v[q*CW +: CW]    = CW'(occ[q]);
      lim_v[q*CW +: CW]    = CW'(lim[q]);
      mc_v[q*MW +: MW]     = MW'(q + 1);
      me_v[q*MW +: MW]     = MW'(q + 20);
      mb_v[q*MW +: MW]     = MW'(q + 40);
      sp_v[q] = sp[q]; ce_v[q] = ce[q]; ee_v[q] = ee[q]; be_v[q] = be[q];
    end
  end

  qs_sched u_qs_sched (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .link_rdy_i(link),
    .head_len_i(head_len), .occ_i(occ_v), .strict_i(sp_v), .cir_en_i(ce_v),
    .eir_en_i(ee_v), .be_en_i(be_v), .cir_inc_i(cinc_v), .cir_burst_i(cbur_v),
    .eir_inc_i(einc_v), .eir_burst_i(ebur_v), .mark_cir_i(mc_v), .mark_eir_i(me_v),
    .mark_be_i(mb_v), .qlim_i(lim_v), .arr_vld_i(arr_vld), .arr_q_i(arr_q),
    .gnt_vld_o(gnt_vld), .gnt_q_o(gnt_q), .gnt_band_o(gnt_band), .gnt_mark_o(gnt_mark),
    .drop_o(drop), .drop_q_o(drop_q)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit elig(int p, int q);
    if (sp[q] || occ[q] == 0) return 0;
    if (p == 1) return ce[q] && ctok[q] >= len[q];
    if (p == 2) return ee[q] && etok[q] >= len[q];
    return be[q];
  endfunction

  function automatic int upd(int tok, int inc, int bur, bit tk, bit take, int l);
    int t = tok;
    if (tk) t = (t + inc > bur) ? bur : t + inc;
    if (take) t = (t >= l) ? t - l : 0;
    return t;
  endfunction

  // one cycle: predict from the model, clock, compare at negedge
  task automatic step(string tag);
    bit ev = 0, edrop;
    int eb = 0, eq = 0, em;
    if (link) begin
      for (int q = 0; q < NQ; q++) if (!ev && sp[q] && occ[q] > 0) begin ev = 1; eb = 0; eq = q; end
      for (int p = 1; p <= 3; p++)
        for (int k = 0; k < NQ; k++) begin
          int q = (ptr[p-1] + k) % NQ;
          if (!ev && elig(p, q)) begin ev = 1; eb = p; eq = q; ptr[p-1] = (q + 1) % NQ; end
        end
    end
    for (int q = 0; q < NQ; q++) begin
      ctok[q] = upd(ctok[q], cinc[q], cbur[q], tick, ev && eb == 1 && eq == q, len[q]);
      etok[q] = upd(etok[q], einc[q], ebur[q], tick, ev && eb == 2 && eq == q, len[q]);
    end
    em = (eb == 2) ? eq + 20 : (eb == 3) ? eq + 40 : eq + 1;
    edrop = arr_vld && occ[arr_q] >= lim[arr_q];
    @(posedge clk); @(negedge clk);
    chk({tag, " R9"}, "gnt_vld", gnt_vld, ev);
    if (ev && gnt_vld) begin
      chk({tag, " R7"}, "gnt_q", gnt_q, eq);
      chk({tag, " R8"}, "band", gnt_band, eb);
      chk({tag, " R8"}, "mark", gnt_mark, em);
    end
    chk({tag, " R10"}, "drop", drop, edrop);
    if (edrop) chk({tag, " R10"}, "drop_q", drop_q, arr_q);
  endtask

  task automatic clear_cfg();
    for (int q = 0; q < NQ; q++) begin
      len[q] = 100; occ[q] = 0; lim[q] = 63; cinc[q] = 0; cbur[q] = 0;
      einc[q] = 0; ebur[q] = 0; sp[q] = 0; ce[q] = 0; ee[q] = 0; be[q] = 0;
    end
    tick = 0; link = 0; arr_vld = 0; arr_q = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    clear_cfg();
    for (int q = 0; q < NQ; q++) begin ctok[q] = 0; etok[q] = 0; end
    for (int p = 0; p < 3; p++) ptr[p] = 0;
    repeat (3) @(negedge clk);
    chk("R1", "gnt_vld in reset", gnt_vld, 0);
    chk("R1", "drop in reset", drop, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: buckets empty, rate bands idle until a tick
    for (int q = 0; q < NQ; q++) begin occ[q] = 2; ce[q] = 1; ee[q] = 1; cbur[q] = 500; ebur[q] = 500; end
    link = 1;
    step("R1");
    chk("R1", "no grant from empty buckets", gnt_vld, 0);

    // R2: refill caps at burst; two 100-byte grants from a 250 cap
    clear_cfg();
    occ[0] = 1; ce[0] = 1; cinc[0] = 100; cbur[0] = 250;
    tick = 1;
    repeat (5) step("R2");
    tick = 0; link = 1; cnt = 0;
    repeat (4) begin
      step("R2");
      if (gnt_vld && gnt_band == 2'd1) cnt++;
    end
    chk("R2", "grants from capped bucket", cnt, 2);

    // R5: opt-in best effort once tokens are short
    be[0] = 1;
    step("R5");
    chk("R5", "best-effort band", gnt_band, 3);
    be[0] = 0; be[3] = 1; occ[3] = 0;
    step("R5");
    chk("R5", "empty queue gets nothing", gnt_vld, 0);

    // R4: committed before excess
    clear_cfg();
    occ[1] = 1; ce[1] = 1; cinc[1] = 500; cbur[1] = 500;
    occ[2] = 1; ee[2] = 1; einc[2] = 500; ebur[2] = 500;
    tick = 1; step("R4"); tick = 0; link = 1;
    step("R4");
    chk("R4", "committed wins", gnt_band, 1);
    occ[1] = 0;
    step("R4");
    chk("R4", "excess next", gnt_band, 2);
    chk("R4", "excess queue", gnt_q, 2);

    // R6: strict beats rate passes, lowest index first
    sp[5] = 1; occ[5] = 1; sp[6] = 1; occ[6] = 1; occ[1] = 1;
    step("R6");
    chk("R6", "strict queue", gnt_q, 5);
    chk("R6", "strict band", gnt_band, 0);
    chk("R6", "strict mark", gnt_mark, 6);

    // R10: exhaustive occupancy/limit sweep
    clear_cfg();
    for (int q = 0; q < NQ; q++)
      for (int o = 0; o < 4; o++)
        for (int l = 0; l < 4; l++) begin
          occ[q] = o; lim[q] = l; arr_vld = 1; arr_q = QW'(q);
          step("R10");
          chk("R10", "drop vs limit", drop, o >= l);
          occ[q] = 0; lim[q] = 63;
        end
    arr_vld = 0;

    // R3 R4 R7: random phases against the arithmetic model
    for (int ph = 0; ph < 24; ph++) begin
      for (int q = 0; q < NQ; q++) begin
        sp[q] = ($urandom % 10) == 0;
        ce[q] = $urandom % 2; ee[q] = $urandom % 2; be[q] = $urandom % 2;
        cinc[q] = $urandom % 300; einc[q] = $urandom % 300;
        cbur[q] = 200 + $urandom % 1800; ebur[q] = 200 + $urandom % 1800;
        lim[q] = 1 + $urandom % 3;
      end
      repeat (200) begin
        for (int q = 0; q < NQ; q++) begin
          len[q] = 64 + $urandom % 1437;
          occ[q] = $urandom % 4;
        end
        tick = ($urandom % 4) == 0;
        link = ($urandom % 4) != 0;
        arr_vld = $urandom % 2; arr_q = QW'($urandom % NQ);
        step("R3");
      end
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule